// File: doc/BRIEF.md
# Upset-Injectable Four-Input Lookup Table

This block is a four-input lookup table whose sixteen truth-table bits can be written either in one parallel cycle or bit by bit through a serial shift path. Next to the programmed table it keeps a fault mask. An injection command with a bit index flips one entry of the table seen by the faulty output, which models a single radiation upset in configuration storage. The faulty copy then gives a wrong answer for exactly one input combination and is correct for all others. It never collapses to a constant output.

The programmed (golden) table and the faulty table are evaluated side by side from the same four data inputs. A combinational mismatch signal is their XOR, and a registered copy of it is kept for observation. An upset lasts until the table is written again or until a scrub command clears the mask. A scrub leaves the programmed contents untouched.

Top module: `seu_lut4`

## Requirements
- R1: After a synchronous active-low reset the programmed table and the fault mask are all zero, so `dout`, `gold_out`, `mism_now` and `mism_q` are 0 for every input pattern.
- R2: A cycle with `cfg_par_we` high loads `cfg_par_data`. Afterwards `gold_out` equals bit `din` of the loaded word, where `din[3]` is x1 (the most significant index bit) and `din[0]` is x4.
- R3: A cycle with `cfg_ser_en` high and `cfg_par_we` low shifts the table left by one and places `cfg_ser_bit` at index 0. After sixteen such cycles the first bit shifted in sits at index 15. When both load controls are high in the same cycle, the parallel word is taken.
- R4: An `inj_stb` pulse inverts table bit `inj_idx` of the faulty copy from the next clock edge. Afterwards `dout` differs from `gold_out` only when `din` equals `inj_idx`.
- R5: Injecting an index that is already flipped restores that bit, because the mask combines requests by XOR. Upsets at different indices accumulate.
- R6: A `scrub_stb` pulse clears the whole fault mask in one cycle and leaves the programmed table unchanged.
- R7: Any table write, parallel or serial, clears the fault mask. An injection in the same cycle as a table write is dropped.
- R8: When `scrub_stb` and `inj_stb` are high in the same cycle, the scrub wins and the mask becomes all zero.
- R9: `mism_now` is `dout` XOR `gold_out` for the present inputs. `mism_q` holds the value `mism_now` had at the previous clock edge.
- R10: With the table 16'hF888, which is (x1 AND x2) OR (x3 AND x4), and bit 0 flipped, `dout` is that function plus a 1 at input 0000 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_par_we | input | 1 | Parallel table write strobe |
| cfg_par_data | input | 16 | Table word; bit i is the output for input pattern i |
| cfg_ser_en | input | 1 | Serial shift enable |
| cfg_ser_bit | input | 1 | Serial bit entering index 0 |
| inj_stb | input | 1 | Upset injection strobe |
| inj_idx | input | 4 | Index of the table bit to flip |
| scrub_stb | input | 1 | Clear the fault mask |
| din | input | 4 | Data inputs x1..x4 (din[3] is x1) |
| dout | output | 1 | Output of the faulty table |
| gold_out | output | 1 | Output of the programmed table |
| mism_now | output | 1 | Combinational faulty/golden difference |
| mism_q | output | 1 | Registered copy of mism_now |

## Verification
Injection can land in the same cycle as a scrub or as a table write. Both of those clear the mask, so the collision decides whether the upset survives. The bench asserts `inj_stb` together with `scrub_stb`, and later together with `cfg_par_we`. It then sweeps all sixteen input patterns and expects `dout` to match `gold_out` everywhere. A separate case drives both load controls high at once to show the parallel word takes priority.

// File: rtl/seu_lut_pkg.sv
// Shared types for the upset-injectable lookup table.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package seu_lut_pkg;
    typedef enum logic [1:0] {
        MASK_HOLD  = 2'd0,
        MASK_CLEAR = 2'd1,
        MASK_FLIP  = 2'd2
    } mask_op_e;
endpackage

// File: rtl/seu_lut_cfg.sv
// Programmed (golden) truth table with a parallel and a serial write path.
// Assumes: DEPTH >= 2. A parallel write takes priority over a shift.
module seu_lut_cfg #(
    parameter int unsigned DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             par_we,
    input  logic [DEPTH-1:0] par_data,
    input  logic             ser_en,
    input  logic             ser_bit,
    output logic [DEPTH-1:0] cfg_q
);
    // Table storage: reset, parallel load or left shift with new bit at index 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (par_we) begin
            cfg_q <= par_data;
        end else if (ser_en) begin
            cfg_q <= {cfg_q[DEPTH-2:0], ser_bit};
        end
    end
endmodule

// File: rtl/seu_lut_mask.sv
// Fault mask: one bit per table entry. A set bit means that entry is inverted.
// Assumes: the caller resolves priority into a single operation per cycle.
module seu_lut_mask
    import seu_lut_pkg::*;
#(
    parameter int unsigned NUM_IN = 4,
    localparam int unsigned DEPTH = 1 << NUM_IN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mask_op_e          op,
    input  logic [NUM_IN-1:0] idx,
    output logic [DEPTH-1:0]  mask_q
);
    logic [DEPTH-1:0] idx_hot;

    // One-hot decode of the injection index
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_dec
        assign idx_hot[gi] = (idx == gi[NUM_IN-1:0]);
    end

    // Mask register: clear, XOR-flip one entry, or hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            case (op)
                MASK_CLEAR: mask_q <= '0;
                MASK_FLIP:  mask_q <= mask_q ^ idx_hot;
                default:    mask_q <= mask_q;
            endcase
        end
    end
endmodule

// File: rtl/seu_lut_mux.sv
// Combinational table read: returns the entry addressed by the select inputs.
// Assumes: sel[NUM_IN-1] is the most significant index bit.
module seu_lut_mux #(
    parameter int unsigned NUM_IN = 4,
    localparam int unsigned DEPTH = 1 << NUM_IN
) (
    input  logic [DEPTH-1:0]  tbl,
    input  logic [NUM_IN-1:0] sel,
    output logic              y
);
    // Table lookup
    assign y = tbl[sel];
endmodule

// File: rtl/seu_lut4.sv
// Upset-injectable lookup table: golden and faulty copies evaluated in parallel.
// Assumes: one control action resolves per cycle with the priority
// table write > scrub > injection.
module seu_lut4
    import seu_lut_pkg::*;
#(
    parameter int unsigned NUM_IN = 4,
    localparam int unsigned DEPTH = 1 << NUM_IN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_par_we,
    input  logic [DEPTH-1:0]  cfg_par_data,
    input  logic              cfg_ser_en,
    input  logic              cfg_ser_bit,
    input  logic              inj_stb,
    input  logic [NUM_IN-1:0] inj_idx,
    input  logic              scrub_stb,
    input  logic [NUM_IN-1:0] din,
    output logic              dout,
    output logic              gold_out,
    output logic              mism_now,
    output logic              mism_q
);
    logic [DEPTH-1:0] gold_cfg;
    logic [DEPTH-1:0] flt_mask;
    logic [DEPTH-1:0] flt_cfg;
    mask_op_e         mask_op;

    seu_lut_cfg #(.DEPTH(DEPTH)) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .par_we   (cfg_par_we),
        .par_data (cfg_par_data),
        .ser_en   (cfg_ser_en),
        .ser_bit  (cfg_ser_bit),
        .cfg_q    (gold_cfg)
    );

    // Resolve the mask operation: a write or a scrub clears, otherwise inject
    always_comb begin
        if (cfg_par_we || cfg_ser_en) begin
            mask_op = MASK_CLEAR;
        end else if (scrub_stb) begin
            mask_op = MASK_CLEAR;
        end else if (inj_stb) begin
            mask_op = MASK_FLIP;
        end else begin
            mask_op = MASK_HOLD;
        end
    end

    seu_lut_mask #(.NUM_IN(NUM_IN)) mask_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (mask_op),
        .idx    (inj_idx),
        .mask_q (flt_mask)
    );

    // Faulty table is the golden table with masked entries inverted
    assign flt_cfg = gold_cfg ^ flt_mask;

    seu_lut_mux #(.NUM_IN(NUM_IN)) gold_mux_i (
        .tbl (gold_cfg),
        .sel (din),
        .y   (gold_out)
    );

    seu_lut_mux #(.NUM_IN(NUM_IN)) flt_mux_i (
        .tbl (flt_cfg),
        .sel (din),
        .y   (dout)
    );

    // Difference between the two copies
    assign mism_now = dout ^ gold_out;

    // Observation register for the difference
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mism_q <= 1'b0;
        end else begin
            mism_q <= mism_now;
        end
    end
endmodule

// File: rtl/seu_lut4_chk.sv
// Property checker for seu_lut4, attached with bind.
// Assumes: sees the golden table and the fault mask of the top module.
module seu_lut4_chk #(
    parameter int unsigned NUM_IN = 4,
    localparam int unsigned DEPTH = 1 << NUM_IN
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_par_we,
    input logic              cfg_ser_en,
    input logic              inj_stb,
    input logic              scrub_stb,
    input logic [NUM_IN-1:0] din,
    input logic              dout,
    input logic              gold_out,
    input logic              mism_now,
    input logic              mism_q,
    input logic [DEPTH-1:0]  gold_cfg,
    input logic [DEPTH-1:0]  flt_mask
);
    // R4
    one_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_stb && !scrub_stb && !cfg_par_we && !cfg_ser_en)
        |=> ($countones(flt_mask ^ $past(flt_mask)) == 1));

    // R4
    err_at_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout != gold_out) |-> flt_mask[din]);

    // R6
    scrub_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scrub_stb && !cfg_par_we && !cfg_ser_en)
        |=> ((flt_mask == '0) && $stable(gold_cfg)));

    // R7
    reload_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_par_we || cfg_ser_en) |=> (flt_mask == '0));

    // R9
    mism_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (mism_q == $past(mism_now)));
endmodule

bind seu_lut4 seu_lut4_chk #(.NUM_IN(NUM_IN)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_par_we (cfg_par_we),
    .cfg_ser_en (cfg_ser_en),
    .inj_stb    (inj_stb),
    .scrub_stb  (scrub_stb),
    .din        (din),
    .dout       (dout),
    .gold_out   (gold_out),
    .mism_now   (mism_now),
    .mism_q     (mism_q),
    .gold_cfg   (gold_cfg),
    .flt_mask   (flt_mask)
);

// File: tb/seu_lut4_tb_top.sv
// Scoreboard bench: driver tasks push expectations, a monitor pops and compares.
module seu_lut4_tb_top;
    localparam int NI = 4;
    localparam int D  = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_par_we, cfg_ser_en, cfg_ser_bit;
    logic [D-1:0]  cfg_par_data;
    logic          inj_stb, scrub_stb;
    logic [NI-1:0] inj_idx, din;
    logic          dout, gold_out, mism_now, mism_q;

    int checks = 0;
    int fails  = 0;
    logic [D-1:0] g_m = '0;
    logic [D-1:0] m_m = '0;
    string       tag_q[$];
    logic [3:0]  exp_q[$];
    event        item_ev;

    always #5 clk = ~clk;

    seu_lut4 #(.NUM_IN(NI)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_par_we(cfg_par_we), .cfg_par_data(cfg_par_data),
        .cfg_ser_en(cfg_ser_en), .cfg_ser_bit(cfg_ser_bit),
        .inj_stb(inj_stb), .inj_idx(inj_idx), .scrub_stb(scrub_stb),
        .din(din), .dout(dout), .gold_out(gold_out),
        .mism_now(mism_now), .mism_q(mism_q)
    );

    // Monitor: item bit 3 selects registered (1) or combinational (0) check
    initial begin
        forever begin
            @(item_ev);
            while (exp_q.size() > 0) begin
                logic [3:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (!e[3]) begin
                    if ({dout, gold_out, mism_now} !== e[2:0]) begin
                        fails++;
                        $display("FAIL %s din=%h actual dout/gold/mism=%b expected=%b",
                                 t, din, {dout, gold_out, mism_now}, e[2:0]);
                    end
                end else if (mism_q !== e[0]) begin
                    fails++;
                    $display("FAIL %s (R9 mism_q) actual=%b expected=%b", t, mism_q, e[0]);
                end
            end
        end
    end

    task automatic probe(input logic [NI-1:0] idx, input string t);
        logic ed, eg;
        @(negedge clk);
        din = idx;
        #2;
        ed = g_m[idx] ^ m_m[idx];
        eg = g_m[idx];
        tag_q.push_back(t); exp_q.push_back({1'b0, ed, eg, ed ^ eg});
        -> item_ev;
        @(posedge clk);
        #2;
        tag_q.push_back(t); exp_q.push_back({1'b1, 2'b00, ed ^ eg});
        -> item_ev;
    endtask

    task automatic sweep(input string t);
        for (int i = 0; i < D; i++) probe(i[NI-1:0], t);
    endtask

    task automatic par_load(input logic [D-1:0] d);
        @(negedge clk);
        cfg_par_we = 1'b1; cfg_par_data = d;
        @(negedge clk);
        cfg_par_we = 1'b0;
        g_m = d; m_m = '0;
    endtask

    task automatic ser_load(input logic [D-1:0] d);
        @(negedge clk);
        cfg_ser_en = 1'b1;
        for (int i = D - 1; i >= 0; i--) begin
            cfg_ser_bit = d[i];
            @(negedge clk);
        end
        cfg_ser_en = 1'b0;
        g_m = d; m_m = '0;
    endtask

    task automatic inject(input logic [NI-1:0] idx);
        @(negedge clk);
        inj_stb = 1'b1; inj_idx = idx;
        @(negedge clk);
        inj_stb = 1'b0;
        m_m[idx] = ~m_m[idx];
    endtask

    task automatic scrub();
        @(negedge clk);
        scrub_stb = 1'b1;
        @(negedge clk);
        scrub_stb = 1'b0;
        m_m = '0;
    endtask

    // Stimulus
    initial begin
        rst_n = 1'b0; cfg_par_we = 1'b0; cfg_ser_en = 1'b0; cfg_ser_bit = 1'b0;
        cfg_par_data = '0; inj_stb = 1'b0; inj_idx = '0; scrub_stb = 1'b0; din = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        sweep("R1 reset state");

        par_load(16'hF888);
        sweep("R2 parallel load of (x1&x2)|(x3&x4)");
        inject(4'd0);
        sweep("R10/R4 flip at 0000");
        inject(4'd0);
        sweep("R5 second flip restores");
        inject(4'd5);
        inject(4'd9);
        sweep("R5 two upsets accumulate");
        scrub();
        sweep("R6 scrub keeps table");

        inject(4'd3);
        ser_load(16'hA5C3);
        sweep("R3/R7 serial load clears mask");

        // R3: both load controls at once, parallel word wins
        @(negedge clk);
        cfg_par_we = 1'b1; cfg_par_data = 16'h1E69; cfg_ser_en = 1'b1; cfg_ser_bit = 1'b1;
        @(negedge clk);
        cfg_par_we = 1'b0; cfg_ser_en = 1'b0;
        g_m = 16'h1E69; m_m = '0;
        sweep("R3 parallel beats serial");

        // R8: scrub and injection together
        inject(4'd7);
        @(negedge clk);
        scrub_stb = 1'b1; inj_stb = 1'b1; inj_idx = 4'd12;
        @(negedge clk);
        scrub_stb = 1'b0; inj_stb = 1'b0;
        m_m = '0;
        sweep("R8 scrub wins over inject");

        // R7: injection during a table write is dropped
        @(negedge clk);
        cfg_par_we = 1'b1; cfg_par_data = 16'h0FF0; inj_stb = 1'b1; inj_idx = 4'd4;
        @(negedge clk);
        cfg_par_we = 1'b0; inj_stb = 1'b0;
        g_m = 16'h0FF0; m_m = '0;
        sweep("R7 inject dropped on write");

        inject(4'd15);
        sweep("R4 flip at 1111 only");

        #20;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog (all requirements) actual=hung expected=complete");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule